// File: doc/BRIEF.md
# Layered Video Plane Priority Mixer

This block composes one output pixel per strobe from six input planes, a background fill and a cursor. There are two video planes and four graphics planes. Each plane presents a colour and an opaque flag for the current raster position. The block picks the colour of the topmost plane that is enabled, placed in the stacking order and opaque. There is no blending: an opaque plane fully covers every plane beneath it.

The stacking order is not fixed by input position. A depth word holds one 3-bit plane code per depth level, and software rearranges the planes by rewriting that word. The cursor stays outside this ordering and always lies on top. Where no plane wins, the background colour fills an inclusive rectangle when the background is enabled; the rest of the screen is black. Pixels outside a programmable active rectangle are always black.

Configuration arrives through a simple write port into shadow registers. The shadow values are copied to the working set only on a frame-start pulse, so the composition never changes part way through a frame. The output colour and its valid flag appear one clock after the input strobe.

Top module: `layer_priority_mixer`

## Requirements
- R1: `out_valid` is high exactly one clock after each cycle with `pix_valid` high and low otherwise; `out_rgb` carries that pixel's composed colour in the same cycle.
- R2: The enable word uses bit 0 for background, bit 1 for video 0, bit 2 for video 1, bits 3..6 for graphics 0..3 and bit 9 for the cursor; a plane whose bit is clear is never shown.
- R3: The depth word has one 3-bit field per depth level, with level i at bits 3*i+2:3*i. Codes 1 and 2 are video 0 and 1, and codes 3..6 are graphics 0..3; codes 0 and 7 leave a level empty. A higher level covers a lower one, and a plane that appears at no level is never shown.
- R4: A plane code that appears at several levels takes the highest of them.
- R5: An enabled, opaque cursor (input `cursor_rgb`) covers every depth-ordered plane.
- R6: When no plane wins, the pixel takes the 24-bit 0xRRGGBB background colour if background is enabled and the position lies inside the inclusive background rectangle; otherwise it is 0x000000.
- R7: A pixel outside the inclusive active rectangle is 0x000000 whatever the plane, cursor and background state.
- R8: Register addresses are 0 enable, 1 depth, 2 background colour, 3 background start, 4 background end, 5 active start and 6 active end. Corner words pack the line in bits 31:16 and the pixel in bits 15:0. A write reaches a shadow copy and takes effect only at the next `frame_start` pulse. A write made in the same cycle as a `frame_start` pulse waits for the pulse after it.
- R9: After reset all configuration is zero, `out_valid` is 0 and `out_rgb` is 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | Frame-start pulse that commits the shadow configuration |
| pix_valid | input | 1 | Pixel strobe |
| pix_x | input | 16 | Pixel number on the line |
| pix_y | input | 16 | Line number |
| plane_rgb | input | 144 | Plane colours, plane k at bits 24k+23:24k (video 0, video 1, graphics 0..3) |
| plane_opaque | input | 6 | Opaque flag per plane |
| cursor_rgb | input | 24 | Cursor colour |
| cursor_opaque | input | 1 | Cursor opaque flag |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composed output colour |

## Verification
A configuration write and the frame-start commit can fall in the same clock. The bench provokes this by raising `cfg_we` and `frame_start` together with a new enable word. It then judges the pixels that follow: they must still show the previously committed planes. Only after the next frame-start pulse may they show the new word. The checker also ties the working enable word to the shadow value sampled at each pulse.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int CW     = 16;
  localparam int RGBW   = 24;
  localparam int NPLANE = 6;
  localparam int IDW    = 3;
  localparam int ENW    = 10;
  localparam int EN_BG  = 0;
  localparam int EN_CUR = 9;

  typedef logic [RGBW-1:0] rgb_t;

  typedef enum logic [2:0] {
    A_ENABLE   = 3'd0,
    A_DEPTH    = 3'd1,
    A_BGCOL    = 3'd2,
    A_BGSTART  = 3'd3,
    A_BGEND    = 3'd4,
    A_ACTSTART = 3'd5,
    A_ACTEND   = 3'd6
  } cfg_addr_e;

  function automatic logic in_rect(input logic [CW-1:0] x, input logic [CW-1:0] y,
                                   input logic [31:0] lo, input logic [31:0] hi);
    return (y >= lo[31:16]) && (y <= hi[31:16]) && (x >= lo[15:0]) && (x <= hi[15:0]);
  endfunction
endpackage

// File: rtl/mix_cfg_regs.sv
module mix_cfg_regs
  import mix_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int DW = DEPTH * IDW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              frame_start,
  output logic [ENW-1:0]    act_en,
  output logic [DW-1:0]     act_depth,
  output rgb_t              act_bgcol,
  output logic [31:0]       act_bgs,
  output logic [31:0]       act_bge,
  output logic [31:0]       act_avs,
  output logic [31:0]       act_ave,
  output logic [ENW-1:0]    shd_en
);
  logic [DW-1:0]  shd_depth, shd_depth_d, act_depth_d;
  logic [ENW-1:0] shd_en_d, act_en_d;
  rgb_t           shd_bgcol, shd_bgcol_d, act_bgcol_d;
  logic [31:0]    shd_bgs, shd_bge, shd_avs, shd_ave;
  logic [31:0]    shd_bgs_d, shd_bge_d, shd_avs_d, shd_ave_d;
  logic [31:0]    act_bgs_d, act_bge_d, act_avs_d, act_ave_d;

  // shadow next state
  always_comb begin
    shd_en_d    = shd_en;
    shd_depth_d = shd_depth;
    shd_bgcol_d = shd_bgcol;
    shd_bgs_d   = shd_bgs;
    shd_bge_d   = shd_bge;
    shd_avs_d   = shd_avs;
    shd_ave_d   = shd_ave;
    if (cfg_we) begin
      case (cfg_addr_e'(cfg_addr))
        A_ENABLE:   shd_en_d    = cfg_wdata[ENW-1:0];
        A_DEPTH:    shd_depth_d = cfg_wdata[DW-1:0];
        A_BGCOL:    shd_bgcol_d = cfg_wdata[RGBW-1:0];
        A_BGSTART:  shd_bgs_d   = cfg_wdata;
        A_BGEND:    shd_bge_d   = cfg_wdata;
        A_ACTSTART: shd_avs_d   = cfg_wdata;
        A_ACTEND:   shd_ave_d   = cfg_wdata;
        default:    ;
      endcase
    end
  end

  // working set next state: copy of the shadow as it stood before this edge
  always_comb begin
    act_en_d    = act_en;
    act_depth_d = act_depth;
    act_bgcol_d = act_bgcol;
    act_bgs_d   = act_bgs;
    act_bge_d   = act_bge;
    act_avs_d   = act_avs;
    act_ave_d   = act_ave;
    if (frame_start) begin
      act_en_d    = shd_en;
      act_depth_d = shd_depth;
      act_bgcol_d = shd_bgcol;
      act_bgs_d   = shd_bgs;
      act_bge_d   = shd_bge;
      act_avs_d   = shd_avs;
      act_ave_d   = shd_ave;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_en    <= '0;
      shd_depth <= '0;
      shd_bgcol <= '0;
      shd_bgs   <= '0;
      shd_bge   <= '0;
      shd_avs   <= '0;
      shd_ave   <= '0;
      act_en    <= '0;
      act_depth <= '0;
      act_bgcol <= '0;
      act_bgs   <= '0;
      act_bge   <= '0;
      act_avs   <= '0;
      act_ave   <= '0;
    end else begin
      if (cfg_we) begin
        shd_en    <= shd_en_d;
        shd_depth <= shd_depth_d;
        shd_bgcol <= shd_bgcol_d;
        shd_bgs   <= shd_bgs_d;
        shd_bge   <= shd_bge_d;
        shd_avs   <= shd_avs_d;
        shd_ave   <= shd_ave_d;
      end
      if (frame_start) begin
        act_en    <= act_en_d;
        act_depth <= act_depth_d;
        act_bgcol <= act_bgcol_d;
        act_bgs   <= act_bgs_d;
        act_bge   <= act_bge_d;
        act_avs   <= act_avs_d;
        act_ave   <= act_ave_d;
      end
    end
  end
endmodule

// File: rtl/mix_depth_resolve.sv
module mix_depth_resolve
  import mix_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int DW = DEPTH * IDW,
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DW-1:0]              depth_word,
  output logic [NPLANE-1:0]          placed,
  output logic [NPLANE-1:0][LW-1:0]  level
);
  for (genvar k = 0; k < NPLANE; k++) begin : g_plane
    localparam logic [IDW-1:0] CODE = IDW'(k + 1);
    always_comb begin
      placed[k] = 1'b0;
      level[k]  = '0;
      // scan bottom to top so the last hit is the highest level
      for (int i = 0; i < DEPTH; i++) begin
        if (depth_word[i*IDW +: IDW] == CODE) begin
          placed[k] = 1'b1;
          level[k]  = LW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/mix_pixel_pick.sv
module mix_pixel_pick
  import mix_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [CW-1:0]             x,
  input  logic [CW-1:0]             y,
  input  logic [NPLANE*RGBW-1:0]    plane_rgb,
  input  logic [NPLANE-1:0]         plane_opaque,
  input  rgb_t                      cursor_rgb,
  input  logic                      cursor_opaque,
  input  logic [ENW-1:0]            en,
  input  logic [NPLANE-1:0]         placed,
  input  logic [NPLANE-1:0][LW-1:0] level,
  input  rgb_t                      bgcol,
  input  logic [31:0]               bgs,
  input  logic [31:0]               bge,
  input  logic [31:0]               avs,
  input  logic [31:0]               ave,
  output logic                      in_active,
  output rgb_t                      rgb
);
  logic [NPLANE-1:0] elig;
  logic              found;
  logic [LW-1:0]     best_lvl;
  rgb_t              best_rgb;
  logic              in_bg;

  for (genvar k = 0; k < NPLANE; k++) begin : g_elig
    assign elig[k] = placed[k] & en[k+1] & plane_opaque[k];
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_rgb = '0;
    for (int k = 0; k < NPLANE; k++) begin
      if (elig[k] && (!found || level[k] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = level[k];
        best_rgb = plane_rgb[k*RGBW +: RGBW];
      end
    end
  end

  assign in_active = in_rect(x, y, avs, ave);
  assign in_bg     = in_rect(x, y, bgs, bge);

  always_comb begin
    if (!in_active)                         rgb = '0;
    else if (en[EN_CUR] && cursor_opaque)   rgb = cursor_rgb;
    else if (found)                         rgb = best_rgb;
    else if (en[EN_BG] && in_bg)            rgb = bgcol;
    else                                    rgb = '0;
  end
endmodule

// File: rtl/layer_priority_mixer.sv
module layer_priority_mixer
  import mix_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_addr,
  input  logic [31:0]            cfg_wdata,
  input  logic                   frame_start,
  input  logic                   pix_valid,
  input  logic [15:0]            pix_x,
  input  logic [15:0]            pix_y,
  input  logic [143:0]           plane_rgb,
  input  logic [5:0]             plane_opaque,
  input  logic [23:0]            cursor_rgb,
  input  logic                   cursor_opaque,
  output logic                   out_valid,
  output logic [23:0]            out_rgb
);
  localparam int DW = DEPTH * IDW;
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [ENW-1:0]            act_en, shd_en;
  logic [DW-1:0]             act_depth;
  rgb_t                      act_bgcol;
  logic [31:0]               act_bgs, act_bge, act_avs, act_ave;
  logic [NPLANE-1:0]         placed;
  logic [NPLANE-1:0][LW-1:0] level;
  logic                      in_active;
  rgb_t                      pix_rgb;

  mix_cfg_regs #(.DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_q_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .act_en(act_en), .act_depth(act_depth), .act_bgcol(act_bgcol),
    .act_bgs(act_bgs), .act_bge(act_bge), .act_avs(act_avs), .act_ave(act_ave),
    .shd_en(shd_en)
  );

  mix_depth_resolve #(.DEPTH(DEPTH)) u_depth (
    .depth_word(act_depth), .placed(placed), .level(level)
  );

  mix_pixel_pick #(.DEPTH(DEPTH)) u_pick (
    .x(pix_x), .y(pix_y), .plane_rgb(plane_rgb), .plane_opaque(plane_opaque),
    .cursor_rgb(cursor_rgb), .cursor_opaque(cursor_opaque),
    .en(act_en), .placed(placed), .level(level), .bgcol(act_bgcol),
    .bgs(act_bgs), .bge(act_bge), .avs(act_avs), .ave(act_ave),
    .in_active(in_active), .rgb(pix_rgb)
  );

  // output stage
  logic valid_d;
  rgb_t rgb_d;
  always_comb begin
    valid_d = pix_valid;
    rgb_d   = out_rgb;
    if (pix_valid) rgb_d = pix_rgb;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= valid_d;
      if (pix_valid) out_rgb <= rgb_d;
    end
  end
endmodule

// File: rtl/mix_checker.sv
module mix_checker (
  input logic        clk,
  input logic        rst_q_n,
  input logic        pix_valid,
  input logic        frame_start,
  input logic [23:0] cursor_rgb,
  input logic        cursor_opaque,
  input logic        in_active,
  input logic [9:0]  act_en,
  input logic [9:0]  shd_en,
  input logic        out_valid,
  input logic [23:0] out_rgb
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    pix_valid |=> out_valid);
  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pix_valid |=> !out_valid);
  // R7
  outside_black_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pix_valid && !in_active) |=> (out_rgb == 24'h0));
  // R5
  cursor_top_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pix_valid && in_active && act_en[9] && cursor_opaque) |=> (out_rgb == $past(cursor_rgb)));
  // R8
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_start |=> (act_en == $past(shd_en)));
  // R8
  hold_midframe_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !frame_start |=> $stable(act_en));
endmodule

bind layer_priority_mixer mix_checker u_mix_chk (
  .clk(clk), .rst_q_n(rst_q_n), .pix_valid(pix_valid), .frame_start(frame_start),
  .cursor_rgb(cursor_rgb), .cursor_opaque(cursor_opaque), .in_active(in_active),
  .act_en(act_en), .shd_en(shd_en), .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/layer_priority_mixer_bench.sv
module layer_priority_mixer_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [2:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic         frame_start;
  logic         pix_valid;
  logic [15:0]  pix_x, pix_y;
  logic [143:0] plane_rgb;
  logic [5:0]   plane_opaque;
  logic [23:0]  cursor_rgb;
  logic         cursor_opaque;
  logic         out_valid;
  logic [23:0]  out_rgb;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  layer_priority_mixer u_layer_priority_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .plane_rgb(plane_rgb), .plane_opaque(plane_opaque),
    .cursor_rgb(cursor_rgb), .cursor_opaque(cursor_opaque),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  function automatic logic [23:0] pcol(input int k);
    return {8'(k + 1), 8'h55, 8'(k * 16)};
  endfunction

  // monitor: pop one expected item per valid output
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected output: actual=%06h expected=none", out_rgb);
      end else begin
        logic [23:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_rgb !== e) begin
          bad++;
          $display("FAIL %s actual=%06h expected=%06h", t, out_rgb, e);
        end
      end
    end
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d, input bit with_frame);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; frame_start = with_frame;
    @(negedge clk);
    cfg_we = 1'b0; frame_start = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pix(input int x, input int y, input logic [5:0] opq, input bit cur,
                     input logic [23:0] e, input string t);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y);
    plane_opaque = opq; cursor_opaque = cur;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; frame_start = 1'b0;
    pix_valid = 1'b0; pix_x = '0; pix_y = '0; plane_opaque = '0;
    cursor_rgb = 24'hABCDEF; cursor_opaque = 1'b0;
    for (int k = 0; k < 6; k++) plane_rgb[k*24 +: 24] = pcol(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    total++;
    if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
      bad++;
      $display("FAIL R9 actual=%b/%06h expected=0/000000", out_valid, out_rgb);
    end

    // shadow writes; enable 0x27F, depth vid0<vid1<gfx0<gfx1<gfx2<gfx3
    cfg_wr(3'd0, 32'h0000_027F, 1'b0);
    cfg_wr(3'd1, 32'h0003_58D1, 1'b0);
    cfg_wr(3'd2, 32'h0020_3040, 1'b0);
    cfg_wr(3'd3, 32'h000A_000A, 1'b0);
    cfg_wr(3'd4, 32'h0014_0014, 1'b0);
    cfg_wr(3'd5, 32'h0000_0000, 1'b0);
    cfg_wr(3'd6, 32'h0063_0063, 1'b0);
    // R8 not yet committed: active area still only (0,0)
    pix(5, 5, 6'h3F, 1'b0, 24'h0, "R8 before commit");
    frame();

    pix(5, 5, 6'h3F, 1'b0, pcol(5), "R3 top level wins");
    pix(5, 5, 6'h03, 1'b0, pcol(1), "R3 video 1 above video 0");
    pix(15, 15, 6'h00, 1'b0, 24'h203040, "R6 background inside");
    pix(20, 10, 6'h00, 1'b0, 24'h203040, "R6 inclusive corner");
    pix(21, 15, 6'h00, 1'b0, 24'h0, "R6 outside background black");
    pix(5, 5, 6'h3F, 1'b1, 24'hABCDEF, "R5 cursor on top");
    pix(100, 5, 6'h3F, 1'b1, 24'h0, "R7 outside active black");
    pix(99, 99, 6'h01, 1'b0, pcol(0), "R7 inclusive active edge");

    // R2 disable graphics 3
    cfg_wr(3'd0, 32'h0000_023F, 1'b0);
    frame();
    pix(5, 5, 6'h3F, 1'b0, pcol(4), "R2 disabled plane hidden");
    // R8 write coinciding with frame start waits a frame
    cfg_wr(3'd0, 32'h0000_0201, 1'b1);
    pix(5, 5, 6'h3F, 1'b0, pcol(4), "R8 same-cycle write deferred");
    frame();
    pix(15, 15, 6'h3F, 1'b0, 24'h203040, "R2 R8 planes off after next frame");

    // R4 duplicate code: gfx0 at levels 0 and 2, vid0 at 1, code 7 at 3
    cfg_wr(3'd0, 32'h0000_027F, 1'b0);
    cfg_wr(3'd1, 32'h0000_0ECB, 1'b0);
    frame();
    pix(5, 5, 6'h05, 1'b0, pcol(2), "R4 highest duplicate level");
    pix(15, 15, 6'h0A, 1'b0, 24'h203040, "R3 unplaced planes hidden");

    // R3 reversed order: gfx3 at level 0, vid0 at level 5
    cfg_wr(3'd1, 32'h0000_8006, 1'b0);
    frame();
    pix(5, 5, 6'h21, 1'b0, pcol(0), "R3 reordered stack");

    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1 missing outputs actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule